// File: doc/BRIEF.md
# Dominant-Run Error Frame Monitor

This block watches the logical receive line of a CAN-style differential bus and measures how long it stays dominant without a break, counting system clock cycles. A valid classical frame never holds the bus dominant for more than five consecutive bits. A longer run therefore points to an error frame: one six-bit active error flag, or flags from the transmitter and a receiver that overlap. Such a run can reach twelve bits. At 500 kbit/s a bit lasts 2 us, so a threshold a little above 10 us (for example 11 us) separates the two cases without any protocol decode.

The monitor does not drive the bus. The receive input first passes through a two-flop synchronizer. A saturating counter then measures each dominant run. When the count first goes past a programmable threshold, the block emits a one-cycle pulse. When the line returns recessive, the run length is latched in clocks. A sequential divider then converts that length to nominal bit times, rounded to the nearest bit, so a reader can tell a single flag (about six bits) from two overlapping flags (up to twelve). The error flag always runs at the nominal rate, even on buses with a faster data phase, so the bit-time input is the nominal bit period.

Top module: `dom_run_mon`

## Requirements
- R1: `rx_i` low is dominant and high is recessive. After the line returns high, `run_clks_o` reports the number of clock cycles the line was sampled low, and it holds that value until the next run ends.
- R2: `err_pulse_o` goes high for exactly one cycle when the run count first exceeds `thresh_i`. This happens at the (`thresh_i`+3)-th rising clock edge after `rx_i` falls (two synchronizer stages plus the counter).
- R3: A run that lasts `thresh_i` clocks or fewer raises no pulse. A longer run raises exactly one pulse, however long it lasts.
- R4: The run counter saturates at 2^CNT_W-1 and does not wrap, so a stuck-dominant line reports the saturated value.
- R5: `run_bits_o` = floor((run_clks + floor(`bit_clks_i`/2)) / `bit_clks_i`), that is, rounding half up. It is valid no more than CNT_W+4 cycles after `run_clks_o` updates.
- R6: `run_bits_o` saturates at 2^LEN_W-1, and `bit_clks_i` = 0 gives that saturated value.
- R7: After reset `err_pulse_o`, `run_clks_o` and `run_bits_o` are all zero.
- R8: The threshold is programmable down to zero. With `thresh_i` = 0, a one-clock dominant glitch raises the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Logical bus receive line, 0 = dominant |
| bit_clks_i | input | BIT_W | Clock cycles per nominal bit |
| thresh_i | input | CNT_W | Run length in clocks that must be exceeded to flag an error frame |
| err_pulse_o | output | 1 | One-cycle pulse per over-threshold run |
| run_clks_o | output | CNT_W | Length of the last completed dominant run, in clocks |
| run_bits_o | output | LEN_W | Last run length rounded to nominal bits |

## Verification
The assertions check on every cycle that:
- the error pulse is never wider than one cycle;
- the pulse only appears while the count is above the threshold and the line was dominant;
- the latched clock count changes only once the line has gone recessive;
- the saturated counter never wraps.

Only the bench scenarios can show the things that depend on arithmetic or on exact latency: the exact edge at which the pulse appears, the rounding at half-bit boundaries, the single pulse over a long run, and the saturation of the bit count and of a stuck-dominant line.

// File: rtl/dom_run_pkg.sv
package dom_run_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o
);
  logic s1_q, s2_q;

  // reset to recessive so no false run after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
    end
  end

  assign rx_o = s2_q;
endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dom_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (!dom_i)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      // fires as the count steps from thresh to thresh+1; never while saturated
      err_q <= dom_i && (cnt_q == thresh_i) && (cnt_q != CNT_MAX);
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = !dom_i && (cnt_q != '0);
  assign err_o  = err_q;
endmodule

// File: rtl/run_bit_div.sv
module run_bit_div
  import dom_run_pkg::*;
#(
  parameter int unsigned DW    = 21,
  parameter int unsigned BIT_W = 12,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    dvd_i,
  input  logic [BIT_W-1:0] dvs_i,
  output logic [LEN_W-1:0] q_o
);
  localparam int unsigned    SW    = $clog2(DW + 1);
  localparam logic [SW-1:0]  STEPS = SW'(DW);
  localparam logic [LEN_W-1:0] Q_MAX = {LEN_W{1'b1}};

  div_state_e       st_q;
  logic [DW-1:0]    dvd_q, quo_q, quo_nxt;
  logic [BIT_W:0]   rem_q, rem_sh, rem_nxt;
  logic [BIT_W-1:0] dvs_q;
  logic [SW-1:0]    step_q;
  logic [LEN_W-1:0] q_q, q_sat;

  always_comb begin
    rem_sh = {rem_q[BIT_W-1:0], dvd_q[DW-1]};
    if (rem_sh >= {1'b0, dvs_q}) begin
      rem_nxt = rem_sh - {1'b0, dvs_q};
      quo_nxt = {quo_q[DW-2:0], 1'b1};
    end else begin
      rem_nxt = rem_sh;
      quo_nxt = {quo_q[DW-2:0], 1'b0};
    end
  end

  generate
    if (LEN_W >= DW) begin : g_wide
      assign q_sat = LEN_W'(quo_nxt);
    end else begin : g_clip
      assign q_sat = (|quo_nxt[DW-1:LEN_W]) ? Q_MAX : quo_nxt[LEN_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DIV_IDLE;
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
      q_q    <= '0;
    end else if (start_i) begin
      // a new run end aborts any division in flight
      dvd_q  <= dvd_i;
      dvs_q  <= dvs_i;
      quo_q  <= '0;
      rem_q  <= '0;
      step_q <= STEPS;
      if (dvs_i == '0) begin
        st_q <= DIV_IDLE;
        q_q  <= Q_MAX;
      end else begin
        st_q <= DIV_RUN;
      end
    end else if (st_q == DIV_RUN) begin
      dvd_q  <= {dvd_q[DW-2:0], 1'b0};
      quo_q  <= quo_nxt;
      rem_q  <= rem_nxt;
      step_q <= step_q - 1'b1;
      if (step_q == SW'(1)) begin
        st_q <= DIV_IDLE;
        q_q  <= q_sat;
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/dom_run_mon.sv
module dom_run_mon #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned BIT_W = 12,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [BIT_W-1:0] bit_clks_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             err_pulse_o,
  output logic [CNT_W-1:0] run_clks_o,
  output logic [LEN_W-1:0] run_bits_o
);
  localparam int unsigned DW = CNT_W + 1;

  logic             rx_s;
  logic             dom_w;
  logic [CNT_W-1:0] cnt_w;
  logic             done_w;
  logic [CNT_W-1:0] len_q;
  logic [DW-1:0]    dvd_w;

  rx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_o   (rx_s)
  );

  assign dom_w = !rx_s;

  run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dom_i    (dom_w),
    .thresh_i (thresh_i),
    .cnt_o    (cnt_w),
    .done_o   (done_w),
    .err_o    (err_pulse_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (done_w) len_q <= cnt_w;
  end

  // half a bit added for round-to-nearest
  assign dvd_w = {1'b0, cnt_w} + DW'(bit_clks_i >> 1);

  run_bit_div #(.DW(DW), .BIT_W(BIT_W), .LEN_W(LEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (done_w),
    .dvd_i   (dvd_w),
    .dvs_i   (bit_clks_i),
    .q_o     (run_bits_o)
  );

  assign run_clks_o = len_q;
endmodule

// File: rtl/dom_run_chk.sv
module dom_run_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dom_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic             err_pulse_o,
  input logic [CNT_W-1:0] run_clks_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_one_cycle_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |=> !err_pulse_o);

  assert_pulse_over_thresh_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> (cnt_i > thresh_i) && $past(dom_i));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dom_i) && $past(cnt_i) == CNT_MAX) |-> cnt_i == CNT_MAX);

  assert_latch_on_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(run_clks_o) |-> !$past(dom_i));
endmodule

bind dom_run_mon dom_run_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dom_i       (dom_w),
  .cnt_i       (cnt_w),
  .thresh_i    (thresh_i),
  .err_pulse_o (err_pulse_o),
  .run_clks_o  (run_clks_o)
);

// File: tb/sim_dom_run_mon.sv
`timescale 1ns/1ps
module sim_dom_run_mon;
  localparam int CNT_W = 12;
  localparam int BIT_W = 8;
  localparam int LEN_W = 8;
  localparam int SLACK = CNT_W + 9;
  localparam int NV    = 8;
  // run clocks, expected pulses, expected bits (bit = 20 clks, thresh = 110)
  localparam int TBL [0:NV-1][0:2] = '{
    '{20, 0, 1}, '{100, 0, 5}, '{110, 0, 6}, '{111, 1, 6},
    '{120, 1, 6}, '{129, 1, 6}, '{130, 1, 7}, '{240, 1, 12}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx = 1'b1;
  logic [BIT_W-1:0] bit_clks = 8'd20;
  logic [CNT_W-1:0] thresh = 12'd110;
  logic             err;
  logic [CNT_W-1:0] run_clks;
  logic [LEN_W-1:0] run_bits;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dom_run_mon #(.CNT_W(CNT_W), .BIT_W(BIT_W), .LEN_W(LEN_W)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .bit_clks_i  (bit_clks),
    .thresh_i    (thresh),
    .err_pulse_o (err),
    .run_clks_o  (run_clks),
    .run_bits_o  (run_bits)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int n, input int exp_clks, input int exp_pulses,
                          input int exp_bits, input string tag);
    int pulses = 0;
    int first = 0;
    @(negedge clk);
    rx = 1'b0;
    for (int k = 1; k <= n + SLACK; k++) begin
      @(negedge clk);
      if (err) begin
        pulses++;
        if (first == 0) first = k;
      end
      if (k == n) rx = 1'b1;
    end
    chk({"R1 ", tag}, "run_clks", int'(run_clks), exp_clks);
    chk({"R3 ", tag}, "pulse count", pulses, exp_pulses);
    if (exp_pulses == 1) chk({"R2 ", tag}, "pulse edge", first, int'(thresh) + 3);
    chk({"R5 ", tag}, "run_bits", int'(run_bits), exp_bits);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", "err after reset", int'(err), 0);
    chk("R7", "run_clks after reset", int'(run_clks), 0);
    chk("R7", "run_bits after reset", int'(run_bits), 0);

    for (int i = 0; i < NV; i++)
      run_case(TBL[i][0], TBL[i][0], TBL[i][1], TBL[i][2], $sformatf("vec%0d", i));

    // stuck dominant: counter saturation, one pulse only
    run_case(5000, 4095, 1, 205, "r4_stuck");
    // R8 zero threshold catches a one-clock glitch
    thresh = '0;
    run_case(1, 1, 1, 0, "R8_glitch");
    thresh = 12'd110;
    // R6 bit count saturation
    bit_clks = 8'd1;
    run_case(300, 300, 1, 255, "R6_sat");
    bit_clks = 8'd0;
    run_case(40, 40, 0, 255, "R6_zero_bit");
    // R1 value held while the line stays recessive
    bit_clks = 8'd20;
    repeat (50) @(negedge clk);
    chk("R1 hold", "run_clks", int'(run_clks), 40);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule